// File: doc/BRIEF.md
# Audio FIFO Bank with Status

This block stores samples for a three-channel serial audio port. It holds three transmit queues and three receive queues. Each queue is 24 bits wide and 8 entries deep by default. The host side is a CPU bus or a DMA engine. It writes samples into a transmit queue and reads samples out of a receive queue, picking the channel with a select field. The serial side works on all channels at once. It takes the head sample from each transmit queue and pushes captured samples into each receive queue.

A single status word shows two kinds of bit.

- **Live flags.** Each queue has full, empty and half-level flags. For a transmit queue the half-level flag means half or more of the entries are free. For a receive queue it means half or more of the entries hold data.
- **Sticky error bits.** An overflow bit records a host write to a full transmit queue. An underflow bit records a host read of an empty receive queue. Software clears a sticky bit by writing 0 to its position. One output, the OR of all sticky bits, can serve as an interrupt.

Each sticky bit is a two-state machine.

- `ERR_CLEAR` moves to `ERR_HELD` on the transition "event", which is an overflow or underflow attempt.
- `ERR_HELD` returns to `ERR_CLEAR` on the transition "clear": a status write with 0 in that bit position, in a cycle with no new event.
- In every other case the state holds.

Top module: `afb_bank`

## Requirements
- R1: After reset every queue is empty.
  - The status word reads 0x1C7E00: transmit empty and transmit half-empty are set for all three channels, receive empty is set for all three channels, and every other bit is 0.
  - `err_any` reads 0.
- R2: Each queue returns samples in the order they were written.
  - The head of transmit queue c appears on `ser_tx_data[24c+23:24c]`. It reads 0 when that queue is empty.
  - `host_rd_data` shows the head of the receive queue named by `host_rd_sel`, in the same cycle, before `host_rd_en` pops it.
- R3: A host write to a full transmit queue sets overflow bit c (status bits 2:0, bit c for channel c). The write is dropped: the queue's contents and count do not change.
- R4: A host read of an empty receive queue sets underflow bit c (status bits 5:3, bit 3+c). It returns 0 on `host_rd_data` and pops nothing.
- R5: A sticky bit stays 1 until a status write (`stat_wr_en`) carries 0 in its position. Writing 1 there leaves it unchanged.
- R6: When an overflow or underflow event and a write-0 clear of the same bit fall in the same cycle, the bit ends at 1.
- R7: Full flags sit at status bits 8:6 (transmit) and 17:15 (receive). Empty flags sit at bits 11:9 (transmit) and 20:18 (receive). All four follow the current occupancy from the cycle after each push or pop.
- R8: Transmit half-empty (status bits 14:12) is 1 exactly when 4 or more of the 8 entries are free.
- R9: Receive half-full (status bits 23:21) is 1 exactly when 4 or more of the 8 entries are occupied.
- R10: Status writes do not change status bits 23:6.
- R11: `err_any` is 1 exactly when any of status bits 5:0 is 1.
- R12: On the serial side, a pop from an empty transmit queue and a push into a full receive queue are dropped. Neither sets any error bit.
- R13: A host select value of 3 (no channel) has no effect. A write with it changes no queue. A read with it returns 0 and sets no underflow bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr_en | input | 1 | Host push into the selected transmit queue |
| host_wr_sel | input | 2 | Transmit channel select |
| host_wr_data | input | 24 | Sample to push |
| host_rd_en | input | 1 | Host pop from the selected receive queue |
| host_rd_sel | input | 2 | Receive channel select |
| host_rd_data | output | 24 | Head of the selected receive queue, or 0 |
| ser_tx_pop | input | 3 | Serial-side pop, one bit per transmit queue |
| ser_tx_data | output | 72 | Transmit heads, channel c in bits 24c+23:24c |
| ser_rx_push | input | 3 | Serial-side push, one bit per receive queue |
| ser_rx_data | input | 72 | Receive samples, channel c in bits 24c+23:24c |
| stat_wr_en | input | 1 | Status write strobe |
| stat_wr_data | input | 24 | Status write value; a 0 in bits 5:0 clears that sticky bit |
| stat_rd | output | 24 | Status word |
| err_any | output | 1 | OR of all sticky error bits |

## Verification
Directed sequences cover several cases:
- filling a queue to the brim and then trying one more write;
- draining a queue past empty;
- status writes of all ones and of single zeros;
- an error event in the same cycle as a clear;
- serial-side over- and under-runs;
- the unused select value.

Each of these separates a dropped operation from an accepted one, and an event-wins policy from a clear-wins one. After those, a long constrained-random run mixes host and serial traffic on all channels in the same cycles. This mix makes every queue cross its half thresholds in both directions. It also catches bookkeeping errors between channels, since a simultaneous push and pop must leave the count unchanged.

// File: rtl/afb_pkg.sv
`timescale 1ns/1ps
package afb_pkg;
    typedef enum logic {
        ERR_CLEAR = 1'b0,
        ERR_HELD  = 1'b1
    } err_state_t;
endpackage

// File: rtl/afb_err_cell.sv
`timescale 1ns/1ps
module afb_err_cell
    import afb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic flag
);
    err_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ERR_CLEAR;
        else        state_q <= state_d;
    end

    // Next state: an event always wins over a same-cycle clear.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_CLEAR: if (evt)         state_d = ERR_HELD;
            ERR_HELD:  if (clr && !evt) state_d = ERR_CLEAR;
            default:                    state_d = ERR_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == ERR_HELD);
    end
endmodule

// File: rtl/afb_fifo.sv
`timescale 1ns/1ps
module afb_fifo #(
    parameter int W            = 24,
    parameter int DEPTH        = 8,
    parameter bit HALF_IS_FULL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty,
    output logic         half
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int HALF = DEPTH / 2;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Pushes on full and pops on empty are dropped here.
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= ptr_inc(wp);
            if (pop_ok)  rp <= ptr_inc(rp);
            unique case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign head  = empty ? '0 : mem[rp];

    generate
        if (HALF_IS_FULL) begin : g_half_full
            assign half = (cnt >= CW'(HALF));
        end else begin : g_half_empty
            assign half = ((CW'(DEPTH) - cnt) >= CW'(HALF));
        end
    endgenerate
endmodule

// File: rtl/afb_bank.sv
`timescale 1ns/1ps
module afb_bank #(
    parameter int   NCH    = 3,
    parameter int   DATA_W = 24,
    parameter int   DEPTH  = 8,
    localparam int  SEL_W  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int  STAT_W = 8 * NCH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_wr_en,
    input  logic [SEL_W-1:0]      host_wr_sel,
    input  logic [DATA_W-1:0]     host_wr_data,
    input  logic                  host_rd_en,
    input  logic [SEL_W-1:0]      host_rd_sel,
    output logic [DATA_W-1:0]     host_rd_data,
    input  logic [NCH-1:0]        ser_tx_pop,
    output logic [NCH*DATA_W-1:0] ser_tx_data,
    input  logic [NCH-1:0]        ser_rx_push,
    input  logic [NCH*DATA_W-1:0] ser_rx_data,
    input  logic                  stat_wr_en,
    input  logic [STAT_W-1:0]     stat_wr_data,
    output logic [STAT_W-1:0]     stat_rd,
    output logic                  err_any
);
    logic [NCH-1:0]    tx_full, tx_empty, tx_half;
    logic [NCH-1:0]    rx_full, rx_empty, rx_half;
    logic [NCH-1:0]    tx_req, rx_req;
    logic [NCH-1:0]    ovf_q, unf_q;
    logic [DATA_W-1:0] rx_head [NCH];

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign tx_req[c] = host_wr_en && (host_wr_sel == SEL_W'(c));
            assign rx_req[c] = host_rd_en && (host_rd_sel == SEL_W'(c));

            afb_fifo #(.W(DATA_W), .DEPTH(DEPTH), .HALF_IS_FULL(1'b0)) u_tx (
                .clk      (clk),
                .rst_n    (rst_n),
                .push     (tx_req[c]),
                .push_data(host_wr_data),
                .pop      (ser_tx_pop[c]),
                .head     (ser_tx_data[c*DATA_W +: DATA_W]),
                .full     (tx_full[c]),
                .empty    (tx_empty[c]),
                .half     (tx_half[c])
            );

            afb_fifo #(.W(DATA_W), .DEPTH(DEPTH), .HALF_IS_FULL(1'b1)) u_rx (
                .clk      (clk),
                .rst_n    (rst_n),
                .push     (ser_rx_push[c]),
                .push_data(ser_rx_data[c*DATA_W +: DATA_W]),
                .pop      (rx_req[c]),
                .head     (rx_head[c]),
                .full     (rx_full[c]),
                .empty    (rx_empty[c]),
                .half     (rx_half[c])
            );

            afb_err_cell u_ovf (
                .clk  (clk),
                .rst_n(rst_n),
                .evt  (tx_req[c] && tx_full[c]),
                .clr  (stat_wr_en && !stat_wr_data[c]),
                .flag (ovf_q[c])
            );

            afb_err_cell u_unf (
                .clk  (clk),
                .rst_n(rst_n),
                .evt  (rx_req[c] && rx_empty[c]),
                .clr  (stat_wr_en && !stat_wr_data[NCH + c]),
                .flag (unf_q[c])
            );
        end
    endgenerate

    always_comb begin
        host_rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (host_rd_sel == SEL_W'(i)) host_rd_data = rx_head[i];
        end
    end

    assign stat_rd = {rx_half, rx_empty, rx_full, tx_half, tx_empty, tx_full, unf_q, ovf_q};
    assign err_any = |{ovf_q, unf_q};
endmodule

// File: rtl/afb_bank_chk.sv
`timescale 1ns/1ps
module afb_bank_chk #(
    parameter int NCH   = 3,
    parameter int SEL_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr_en,
    input logic [SEL_W-1:0]   host_wr_sel,
    input logic               host_rd_en,
    input logic [SEL_W-1:0]   host_rd_sel,
    input logic               stat_wr_en,
    input logic [8*NCH-1:0]   stat_wr_data,
    input logic [8*NCH-1:0]   stat_rd,
    input logic               err_any
);
    localparam int UNF = NCH;
    localparam int TXF = 2 * NCH;
    localparam int TXE = 3 * NCH;
    localparam int TXH = 4 * NCH;
    localparam int RXF = 5 * NCH;
    localparam int RXE = 6 * NCH;
    localparam int RXH = 7 * NCH;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chk
            a_r3_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
                host_wr_en && host_wr_sel == SEL_W'(c) && stat_rd[TXF+c] |=> stat_rd[c]);
            a_r4_unf_set: assert property (@(posedge clk) disable iff (!rst_n)
                host_rd_en && host_rd_sel == SEL_W'(c) && stat_rd[RXE+c] |=> stat_rd[UNF+c]);
            a_r5_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
                stat_rd[c] && !(stat_wr_en && !stat_wr_data[c]) |=> stat_rd[c]);
            a_r5_unf_hold: assert property (@(posedge clk) disable iff (!rst_n)
                stat_rd[UNF+c] && !(stat_wr_en && !stat_wr_data[UNF+c]) |=> stat_rd[UNF+c]);
            a_r7_tx_excl: assert property (@(posedge clk) disable iff (!rst_n)
                !(stat_rd[TXF+c] && stat_rd[TXE+c]));
            a_r7_rx_excl: assert property (@(posedge clk) disable iff (!rst_n)
                !(stat_rd[RXF+c] && stat_rd[RXE+c]));
            a_r8_tx_half: assert property (@(posedge clk) disable iff (!rst_n)
                stat_rd[TXE+c] |-> stat_rd[TXH+c] && !stat_rd[TXF+c]);
            a_r9_rx_half: assert property (@(posedge clk) disable iff (!rst_n)
                stat_rd[RXF+c] |-> stat_rd[RXH+c]);
        end
    endgenerate

    a_r11_err_any: assert property (@(posedge clk) disable iff (!rst_n)
        err_any == (|stat_rd[2*NCH-1:0]));
endmodule

bind afb_bank afb_bank_chk #(.NCH(NCH), .SEL_W(SEL_W)) u_afb_bank_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr_en  (host_wr_en),
    .host_wr_sel (host_wr_sel),
    .host_rd_en  (host_rd_en),
    .host_rd_sel (host_rd_sel),
    .stat_wr_en  (stat_wr_en),
    .stat_wr_data(stat_wr_data),
    .stat_rd     (stat_rd),
    .err_any     (err_any)
);

// File: tb/test_afb_bank.sv
`timescale 1ns/1ps
module test_afb_bank;
    localparam int NCH = 3;
    localparam int W   = 24;
    localparam int D   = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           host_wr_en = 1'b0;
    logic [1:0]     host_wr_sel = '0;
    logic [W-1:0]   host_wr_data = '0;
    logic           host_rd_en = 1'b0;
    logic [1:0]     host_rd_sel = '0;
    logic [W-1:0]   host_rd_data;
    logic [NCH-1:0] ser_tx_pop = '0;
    logic [NCH*W-1:0] ser_tx_data;
    logic [NCH-1:0] ser_rx_push = '0;
    logic [NCH*W-1:0] ser_rx_data = '0;
    logic           stat_wr_en = 1'b0;
    logic [23:0]    stat_wr_data = '0;
    logic [23:0]    stat_rd;
    logic           err_any;

    always #2.5 clk = ~clk;

    afb_bank #(.NCH(NCH), .DATA_W(W), .DEPTH(D)) i_afb_bank (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_sel(host_rd_sel), .host_rd_data(host_rd_data),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
        .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
        .stat_rd(stat_rd), .err_any(err_any)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0]   mtx [NCH][D];
    logic [W-1:0]   mrx [NCH][D];
    int             ntx [NCH];
    int             nrx [NCH];
    logic [NCH-1:0] m_ovf = '0;
    logic [NCH-1:0] m_unf = '0;

    task automatic chk(input string tag, input logic [71:0] got, input logic [71:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [23:0] exp_stat();
        logic [23:0] s = '0;
        for (int c = 0; c < NCH; c++) begin
            s[c]      = m_ovf[c];
            s[3 + c]  = m_unf[c];
            s[6 + c]  = (ntx[c] == D);
            s[9 + c]  = (ntx[c] == 0);
            s[12 + c] = ((D - ntx[c]) >= D / 2);
            s[15 + c] = (nrx[c] == D);
            s[18 + c] = (nrx[c] == 0);
            s[21 + c] = (nrx[c] >= D / 2);
        end
        return s;
    endfunction

    function automatic logic [71:0] exp_heads();
        logic [71:0] h = '0;
        for (int c = 0; c < NCH; c++) begin
            if (ntx[c] > 0) h[c*W +: W] = mtx[c][0];
        end
        return h;
    endfunction

    task automatic cmp_all();
        logic [23:0] s = exp_stat();
        chk("R5 sticky bits", 72'(stat_rd[5:0]), 72'(s[5:0]));
        chk("R7 full/empty", 72'({stat_rd[20:15], stat_rd[11:6]}), 72'({s[20:15], s[11:6]}));
        chk("R8 tx half-empty", 72'(stat_rd[14:12]), 72'(s[14:12]));
        chk("R9 rx half-full", 72'(stat_rd[23:21]), 72'(s[23:21]));
        chk("R11 err_any", 72'(err_any), 72'(|s[5:0]));
        chk("R2 tx heads", ser_tx_data, exp_heads());
    endtask

    task automatic step(input bit we, input int ws, input logic [W-1:0] wd,
                        input bit re, input int rs,
                        input logic [NCH-1:0] tp, input logic [NCH-1:0] rp,
                        input logic [NCH*W-1:0] rdin,
                        input bit se, input logic [23:0] sd);
        logic [W-1:0] erd;
        host_wr_en   = we;
        host_wr_sel  = ws[1:0];
        host_wr_data = wd;
        host_rd_en   = re;
        host_rd_sel  = rs[1:0];
        ser_tx_pop   = tp;
        ser_rx_push  = rp;
        ser_rx_data  = rdin;
        stat_wr_en   = se;
        stat_wr_data = sd;
        #1;
        erd = (rs < NCH && nrx[rs] > 0) ? mrx[rs][0] : '0;
        chk(erd == '0 ? "R4 read data" : "R2 read data", 72'(host_rd_data), 72'(erd));
        for (int c = 0; c < NCH; c++) begin
            bit pt  = we && ws == c;
            bit ev_o = pt && ntx[c] == D;
            bit ok_pu = pt && ntx[c] < D;
            bit ok_po = tp[c] && ntx[c] > 0;
            bit pr  = re && rs == c;
            bit ev_u = pr && nrx[c] == 0;
            bit ok_rpo = pr && nrx[c] > 0;
            bit ok_rpu = rp[c] && nrx[c] < D;
            if (ok_po) begin
                for (int k = 0; k < D - 1; k++) mtx[c][k] = mtx[c][k+1];
                ntx[c]--;
            end
            if (ok_pu) begin mtx[c][ntx[c]] = wd; ntx[c]++; end
            if (ok_rpo) begin
                for (int k = 0; k < D - 1; k++) mrx[c][k] = mrx[c][k+1];
                nrx[c]--;
            end
            if (ok_rpu) begin mrx[c][nrx[c]] = rdin[c*W +: W]; nrx[c]++; end
            m_ovf[c] = ev_o | (m_ovf[c] & !(se && !sd[c]));
            m_unf[c] = ev_u | (m_unf[c] & !(se && !sd[NCH + c]));
        end
        @(posedge clk);
        #1;
        cmp_all();
    endtask

    task automatic idle();
        step(0, 0, '0, 0, 0, '0, '0, '0, 0, '0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < NCH; c++) begin ntx[c] = 0; nrx[c] = 0; end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        chk("R1 reset status", 72'(stat_rd), 72'(24'h1C7E00));
        chk("R1 reset err_any", 72'(err_any), 72'(0));
        @(posedge clk);
        #1;

        // Fill tx0, then one write too many
        for (int i = 0; i < D; i++) step(1, 0, W'(24'h100 + i), 0, 0, '0, '0, '0, 0, '0);
        chk("R7 tx0 full", 72'(stat_rd[6]), 72'(1));
        step(1, 0, 24'hBADBAD, 0, 0, '0, '0, '0, 0, '0);
        chk("R3 overflow set", 72'(stat_rd[0]), 72'(1));
        chk("R3 head kept", 72'(ser_tx_data[23:0]), 72'(24'h100));
        for (int i = 0; i < D + 1; i++) step(0, 0, '0, 0, 0, 3'b001, '0, '0, 0, '0);

        // Read from empty rx1
        step(0, 0, '0, 1, 1, '0, '0, '0, 0, '0);
        chk("R4 underflow set", 72'(stat_rd[4]), 72'(1));

        // Status writes: ones keep, live flags untouched
        step(0, 0, '0, 0, 0, '0, '0, '0, 1, 24'hFFFFFF);
        chk("R5 ones keep", 72'(stat_rd[5:0]), 72'(6'b010001));
        chk("R10 live flags", 72'(stat_rd[23:6]), 72'(exp_stat() >> 6));
        step(0, 0, '0, 0, 0, '0, '0, '0, 1, 24'h000000);
        chk("R10 live flags zero write", 72'(stat_rd[23:6]), 72'(exp_stat() >> 6));
        chk("R5 cleared", 72'(stat_rd[5:0]), 72'(0));

        // Event beats clear
        for (int i = 0; i < D; i++) step(1, 2, W'(24'h200 + i), 0, 0, '0, '0, '0, 0, '0);
        step(0, 0, '0, 1, 0, '0, '0, '0, 0, '0);
        step(1, 2, 24'h0DEAD0, 0, 0, '0, '0, '0, 1, 24'h000000);
        chk("R6 event wins", 72'(stat_rd[5:0]), 72'(6'b000100));
        step(1, 2, 24'h0DEAD1, 1, 0, '0, '0, '0, 1, 24'h000000);
        chk("R6 both events win", 72'(stat_rd[5:0]), 72'(6'b001100));
        for (int i = 0; i < D; i++) step(0, 0, '0, 0, 0, 3'b100, '0, '0, 0, '0);
        step(0, 0, '0, 0, 0, '0, '0, '0, 1, 24'h000000);

        // Serial-side overrun/underrun
        for (int i = 0; i < D + 1; i++) step(0, 0, '0, 0, 0, 3'b010, 3'b001, 72'(24'h300 + i), 0, '0);
        chk("R12 no error", 72'({err_any, stat_rd[5:0]}), 72'(0));
        chk("R12 rx0 full", 72'(stat_rd[15]), 72'(1));
        for (int i = 0; i < D; i++) step(0, 0, '0, 1, 0, '0, '0, '0, 0, '0);

        // Out-of-range select
        step(1, 3, 24'h777777, 0, 0, '0, 3'b100, {24'h444444, 48'h0}, 0, '0);
        chk("R13 write ignored", 72'(stat_rd), 72'(exp_stat()));
        chk("R13 tx heads", ser_tx_data, 72'(0));
        step(0, 0, '0, 1, 3, '0, '0, '0, 0, '0);
        chk("R13 no underflow", 72'(stat_rd[5:0]), 72'(0));
        chk("R13 rx2 kept", 72'(stat_rd[20]), 72'(0));
        step(0, 0, '0, 1, 2, '0, '0, '0, 0, '0);
        idle();

        // Constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r0 = $urandom;
            logic [31:0] r1 = $urandom;
            logic [95:0] r96 = {$urandom, $urandom, $urandom};
            bit we = r0[0];
            int ws = int'(r0[2:1]);
            bit re = (r0[5:3] < 3);
            int rs = int'(r0[7:6]);
            logic [NCH-1:0] tp = r0[10:8] & r0[13:11];
            logic [NCH-1:0] rp = r0[16:14];
            bit se = (r0[20:17] == 4'd0);
            step(we, ws, r1[23:0], re, rs, tp, rp, r96[71:0], se, r96[95:72]);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule